// File: doc/BRIEF.md
# Iterative Binary-to-BCD Converter

This block turns an unsigned binary integer into its decimal value, one 8421 BCD digit per nibble of the result. It works by repeated decimal doubling, most significant binary bit first. On each clock it takes in one group of four operand bits. The decimal accumulator is doubled four times in a row, and each doubling shifts in one of the bits as the new least significant unit. A 64-bit operand therefore takes 16 working cycles.

Each accumulator digit is held in a redundant six-wire code. The wires carry the weights 8, 6, 4, 2, 0 and 1. Exactly one of the five even-weight wires is high, and the weight-1 wire adds one to it. In this code, doubling a digit and forming its carry takes only two gate levels, so four doublings fit in one cycle. The code is decoded to plain BCD only at the output.

A caller presents the operand together with a start pulse while the block is idle. It then waits for the one-cycle done pulse and reads the result, which stays put until the next accepted start.

Top module: `bin2bcd_iter`

## Requirements
- R1: After reset, busy and done are 0 and bcd_out reads as all zero digits.
- R2: A start seen while busy is 0 is accepted on that rising edge and captures bin_in. busy is then 1 for exactly BIN_W/4 cycles (16 for 64 bits).
- R3: done is 1 for exactly one cycle. That cycle follows the (BIN_W/4)-th rising edge after the accepting edge, which is the first cycle in which busy is back to 0.
- R4: When done is 1, bcd_out holds the decimal value of the captured operand. Decimal digit i sits in bits [4i+3:4i] in 8421 code, with digit 0 the least significant. The digit count is floor(BIN_W*0.30103)+1, which is 20 for 64 bits.
- R5: A start that arrives while busy is 1 is ignored. The running conversion and its result are unaffected.
- R6: bcd_out keeps its value from the done cycle until the next accepted start.
- R7: Every internal digit is always a legal six-wire code. The wires are ordered [8,6,4,2,0,1] from bit 5 down to bit 0, with exactly one of bits 5..1 set. Zero is 000010 and nine is 100001. Every decoded digit value 0 to 9 converts correctly.
- R8: The extreme operands convert correctly. Zero gives all zero digits. 2^BIN_W-1 fills the top digit, and the carry out of the top digit is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to convert bin_in; honoured only when idle |
| bin_in | input | BIN_W | Unsigned binary operand |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: bcd_out is valid |
| bcd_out | output | 4*DIGITS | Decimal result, 8421 digits, least significant in the low nibble |

## Verification
The operand is taken on the rising edge that sees start. busy is seen high at the next falling edge. done is first seen at the falling edge that follows the sixteenth rising edge after the accepting one, and it must be gone one edge later. The bench drives start and samples on falling edges, and counts edges from the accepting one. It therefore requires done at exactly count 16 and compares bcd_out in that same cycle against a divide-by-ten reference. Hold checks read bcd_out again one and several cycles after done. Mid-conversion starts are placed at fixed counts so that their effect, if any, would show in the same result.

// File: rtl/bin2bcd_pkg.sv
package bin2bcd_pkg;

  // Six-wire digit: bit5=w8, bit4=w6, bit3=w4, bit2=w2, bit1=w0, bit0=w1
  typedef logic [5:0] rdig_t;

  localparam rdig_t RD_ZERO = 6'b000010;

  // Number of decimal digits needed for an unsigned value of w bits
  function automatic int calc_digits(input int w);
    return (w * 30103) / 100000 + 1;
  endfunction

  // Double a digit; cin becomes the weight-1 wire of the result
  function automatic rdig_t rd_double(input rdig_t x, input logic cin);
    rdig_t y;
    y[5] = (x[5] & x[0]) | (x[3] & ~x[0]);
    y[4] = (x[2] & x[0]) | (x[5] & ~x[0]);
    y[3] = (x[4] & x[0]) | (x[2] & ~x[0]);
    y[2] = (x[1] & x[0]) | (x[4] & ~x[0]);
    y[1] = (x[3] & x[0]) | (x[1] & ~x[0]);
    y[0] = cin;
    return y;
  endfunction

  // Carry produced when a digit is doubled (value >= 5)
  function automatic logic rd_carry(input rdig_t x);
    return x[5] | x[4] | (x[3] & x[0]);
  endfunction

  // Six-wire digit to 8421 BCD
  function automatic logic [3:0] rd_to_bcd(input rdig_t x);
    return {x[5], x[3] | x[4], x[2] | x[4], x[0]};
  endfunction

  // Legal code: exactly one even-weight wire set
  function automatic logic rd_valid(input rdig_t x);
    int n;
    n = 0;
    for (int i = 1; i < 6; i++) n += int'(x[i]);
    return n == 1;
  endfunction

endpackage

// File: rtl/rd_double_stage.sv
module rd_double_stage
  import bin2bcd_pkg::*;
#(
  parameter int DIGITS = 20,
  localparam int ACC_W = 6 * DIGITS
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             carry_o
);

  logic [DIGITS:0] cin;
  assign cin[0] = bit_i;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    rdig_t x;
    assign x              = acc_i[6*d +: 6];
    assign acc_o[6*d +: 6] = rd_double(x, cin[d]);
    assign cin[d+1]       = rd_carry(x);
  end

  assign carry_o = cin[DIGITS];

endmodule

// File: rtl/rd_group_step.sv
module rd_group_step
  import bin2bcd_pkg::*;
#(
  parameter int DIGITS = 20,
  parameter int STEPS  = 4,
  localparam int ACC_W = 6 * DIGITS
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [STEPS-1:0] bits_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o
);

  logic [ACC_W-1:0] chain [STEPS+1];
  logic [STEPS-1:0] carries;

  assign chain[0] = acc_i;

  // Most significant bit of the group is absorbed first
  for (genvar s = 0; s < STEPS; s++) begin : g_step
    rd_double_stage #(.DIGITS(DIGITS)) u_stage (
      .acc_i  (chain[s]),
      .bit_i  (bits_i[STEPS-1-s]),
      .acc_o  (chain[s+1]),
      .carry_o(carries[s])
    );
  end

  assign acc_o = chain[STEPS];
  assign ovf_o = |carries;

endmodule

// File: rtl/b2d_seq.sv
module b2d_seq #(
  parameter int GROUPS = 16,
  localparam int CNT_W = $clog2(GROUPS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  logic [CNT_W-1:0] left_q;
  logic             busy_q;
  logic             done_q;
  logic             last_grp;

  assign load     = start & ~busy_q;
  assign step     = busy_q;
  assign last_grp = busy_q && (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_grp;
      if (load) begin
        left_q <= CNT_W'(GROUPS);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        left_q <= left_q - CNT_W'(1);
        if (last_grp) busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/bin2bcd_iter.sv
module bin2bcd_iter
  import bin2bcd_pkg::*;
#(
  parameter int BIN_W = 64,
  localparam int GRP_BITS = 4,
  localparam int GROUPS   = BIN_W / GRP_BITS,
  localparam int DIGITS   = calc_digits(BIN_W),
  localparam int ACC_W    = 6 * DIGITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [BIN_W-1:0]      bin_in,
  output logic                  busy,
  output logic                  done,
  output logic [4*DIGITS-1:0]   bcd_out
);

  logic [BIN_W-1:0]    opnd_q;
  logic [ACC_W-1:0]    acc_q;
  logic [ACC_W-1:0]    acc_nxt;
  logic [GRP_BITS-1:0] grp_bits;
  logic                load;
  logic                step;
  logic                step_ovf;

  b2d_seq #(.GROUPS(GROUPS)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .load (load),
    .step (step),
    .busy (busy),
    .done (done)
  );

  assign grp_bits = opnd_q[BIN_W-1 -: GRP_BITS];

  rd_group_step #(.DIGITS(DIGITS), .STEPS(GRP_BITS)) u_step (
    .acc_i (acc_q),
    .bits_i(grp_bits),
    .acc_o (acc_nxt),
    .ovf_o (step_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      acc_q  <= {DIGITS{RD_ZERO}};
    end else if (load) begin
      opnd_q <= bin_in;
      acc_q  <= {DIGITS{RD_ZERO}};
    end else if (step) begin
      opnd_q <= opnd_q << GRP_BITS;
      acc_q  <= acc_nxt;
    end
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_out
    assign bcd_out[4*d +: 4] = rd_to_bcd(acc_q[6*d +: 6]);
  end

endmodule

// File: rtl/bin2bcd_iter_chk.sv
module bin2bcd_iter_chk
  import bin2bcd_pkg::*;
#(
  parameter int BIN_W = 64,
  localparam int GROUPS = BIN_W / 4,
  localparam int DIGITS = calc_digits(BIN_W),
  localparam int ACC_W  = 6 * DIGITS,
  localparam int CNT_W  = $clog2(GROUPS + 2)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [4*DIGITS-1:0] bcd_out,
  input logic [ACC_W-1:0]    acc,
  input logic                ovf
);

  logic [CNT_W-1:0] busy_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cyc <= '0;
    else if (start && !busy)   busy_cyc <= '0;
    else if (busy)             busy_cyc <= busy_cyc + CNT_W'(1);
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cyc == CNT_W'(GROUPS))); // R2

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && busy_cyc < CNT_W'(GROUPS - 1)) |=> busy); // R5

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(bcd_out)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ovf); // R8

  always @(posedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < DIGITS; d++) begin
        AST_CODE_VALID: assert (rd_valid(acc[6*d +: 6])); // R7
      end
    end
  end

endmodule

bind bin2bcd_iter bin2bcd_iter_chk #(.BIN_W(BIN_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .bcd_out(bcd_out),
  .acc    (acc_q),
  .ovf    (step_ovf)
);

// File: tb/bin2bcd_iter_tb.sv
module bin2bcd_iter_tb;

  localparam int BW  = 64;
  localparam int ND  = 20;
  localparam int GRP = BW / 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [BW-1:0]   bin_in = '0;
  logic            busy;
  logic            done;
  logic [4*ND-1:0] bcd_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  bin2bcd_iter #(.BIN_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bin_in(bin_in),
    .busy(busy), .done(done), .bcd_out(bcd_out)
  );

  function automatic logic [4*ND-1:0] ref_bcd(input logic [BW-1:0] v);
    logic [4*ND-1:0] r;
    logic [BW-1:0]   t;
    r = '0;
    t = v;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [4*ND-1:0] act, input logic [4*ND-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  // One conversion; optional second start while busy (R5)
  task automatic convert(input logic [BW-1:0] v, input string req, input bit mid);
    logic [4*ND-1:0] exp;
    logic [4*ND-1:0] held;
    int k;
    exp = ref_bcd(v);
    @(negedge clk);
    start  = 1'b1;
    bin_in = v;
    @(negedge clk);
    start  = 1'b0;
    bin_in = ~v;
    chk(busy === 1'b1, "R2 busy after accept", 80'(busy), 80'(1));
    k = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (done === 1'b1) begin
        k = i;
        break;
      end
      if (mid && i == 5) start = 1'b1;
      if (mid && i == 7) start = 1'b0;
    end
    start = 1'b0;
    chk(k == GRP, "R3 done timing", 80'(k), 80'(GRP));
    chk(busy === 1'b0, "R2 busy length", 80'(busy), 80'(0));
    chk(bcd_out === exp, {req, mid ? " R5 mid start" : ""}, bcd_out, exp);
    held = bcd_out;
    @(negedge clk);
    chk(done === 1'b0, "R3 single pulse", 80'(done), 80'(0));
    repeat (3) @(negedge clk);
    chk(bcd_out === held, "R6 hold", bcd_out, held);
  endtask

  initial begin
    logic [BW-1:0] v;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy reset", 80'(busy), 80'(0));
    chk(done === 1'b0, "R1 done reset", 80'(done), 80'(0));
    chk(bcd_out === '0, "R1 bcd reset", bcd_out, '0);
    rst_n = 1'b1;

    convert(64'd0, "R8 zero", 1'b0);
    convert(64'hFFFF_FFFF_FFFF_FFFF, "R8 max", 1'b0);
    convert(64'd10000000000000000000, "R8 ten to 19", 1'b0);
    convert(64'd1, "R4 one", 1'b0);
    convert(64'd9, "R7 digit nine", 1'b0);
    convert(64'd1234567890, "R7 all digits", 1'b0);
    convert(64'd9876543210987654321, "R7 all digits desc", 1'b0);
    convert(64'd99999999999999999, "R4 nines", 1'b0);
    convert(64'd4242, "R5 busy start", 1'b1);
    convert(64'hFEDC_BA98_7654_3210, "R5 busy start wide", 1'b1);

    for (int n = 0; n < 30; n++) begin
      v = {$urandom, $urandom};
      v = v >> ($urandom % 64);
      convert(v, "R4 random", (n % 5) == 0);
    end

    // R6: idle with changing bin_in and no start leaves result alone
    bin_in = 64'd777;
    repeat (4) @(negedge clk);
    chk(bcd_out === ref_bcd(v), "R6 idle input change", bcd_out, ref_bcd(v));

    finish_run();
  end

endmodule